// File: doc/BRIEF.md
# Collision Presence Signal Controller

This block drives the collision-presence pair that a coaxial transceiver returns to its attached station. It merges three requests into one gated square wave: a jabber guard that latches off a transmitter that has run for too long, a heartbeat that sends a short burst shortly after each transmission ends, and a collision indication taken from an external average-level comparator flag. Whenever at least one request is active, the pair carries a square wave at one tenth of the clock rate, with the two lines in opposite states. With no request, both lines are held low, which is the zero-differential idle state.

The jabber guard watches the transmit-data-valid input. It counts consecutive valid cycles. Once that run reaches a trip limit, it sets a latch that disables the transmitter and keeps the pair active. The latch clears only after a full quiet window with no valid data. Any valid cycle inside that window starts the window again. The end-of-transmit pulse arms a delayed one-shot burst. The heartbeat-enable input gates both the heartbeat and the collision request. All real-time intervals are parameters counted in clock cycles.

Top module: `coll_presence_ctrl`

## Requirements
- R1: After a synchronous reset, `tx_disable`, `cp_pos` and `cp_neg` are all 0.
- R2: `tx_disable` becomes 1 at the clock edge that samples the JAB_TRIP_CYC-th consecutive cycle with `tx_valid` high. A shorter run followed by a low cycle leaves it at 0 and clears the run count.
- R3: While `tx_disable` is 1, the pair is active on the following edge, whatever the state of `hb_en`.
- R4: The latch clears at the edge that samples the JAB_REL_CYC-th consecutive cycle with `tx_valid` low. Any high cycle restarts that count. After a release, a fresh full run of JAB_TRIP_CYC valid cycles is needed to trip again.
- R5: Suppose a `tx_end` pulse is sampled high with `hb_en` high at edge E. The pair is then idle through edge E+HB_DELAY_CYC and active from edge E+HB_DELAY_CYC+1 through edge E+HB_DELAY_CYC+HB_LEN_CYC, provided no other request is present.
- R6: With `hb_en` low, a `tx_end` pulse starts no burst. A pending burst is gated off, and `coll_flag` has no effect on the pair.
- R7: With `coll_flag` and `hb_en` both high at an edge, the pair is active after that edge.
- R8: When active, the pair is driven from a free-running phase counter of period CLK_DIV cycles that starts at 0 after reset. At an edge that samples phase p, `cp_pos` takes the value (p < CLK_DIV/2) and `cp_neg` takes its complement. The two lines are never high together.
- R9: At an edge where no request is present, both `cp_pos` and `cp_neg` become 0.
- R10: A new `tx_end` pulse during the heartbeat delay or burst restarts the delay from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (100 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Valid transmit data present |
| tx_end | input | 1 | One-cycle pulse at end of a transmission |
| coll_flag | input | 1 | Average-level collision comparator flag |
| hb_en | input | 1 | Heartbeat and collision signalling enable |
| tx_disable | output | 1 | Jabber latch: transmitter output disabled |
| cp_pos | output | 1 | Collision-presence positive line |
| cp_neg | output | 1 | Collision-presence negative line |

## Verification
The hardest situation to reach from the ports is the latch release: it needs a full trip run, then a quiet window that is broken by a single valid cycle just before it completes, then a second complete window. Directed sequences place that stray cycle a few cycles before the end and then check the exact cycle of the release. A retriggered heartbeat is the other narrow case: a second end pulse lands one cycle before the first burst would begin, and the bench checks that the pair stays idle at that point. Random episodes of transmissions and quiet periods, some longer than the trip limit, run with random collision flags and occasional heartbeat-enable drops. Their outputs are compared every cycle against a cycle model in the bench.

// File: rtl/coll_pkg.sv
package coll_pkg;

    typedef enum logic [1:0] {
        HB_IDLE  = 2'd0,
        HB_WAIT  = 2'd1,
        HB_BURST = 2'd2
    } hb_state_e;

    typedef struct packed {
        logic jabber;
        logic heartbeat;
        logic collision;
    } cp_req_t;

    function automatic logic req_any(cp_req_t r);
        return r.jabber | r.heartbeat | r.collision;
    endfunction

    function automatic int unsigned cnt_bits(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/jabber_timer.sv
module jabber_timer
    import coll_pkg::*;
#(
    parameter int unsigned TRIP_CYC = 2000,
    parameter int unsigned REL_CYC  = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_valid,
    output logic latched
);
    localparam int unsigned TW = cnt_bits(TRIP_CYC);
    localparam int unsigned RW = cnt_bits(REL_CYC);
    localparam logic [TW-1:0] TRIP_LAST = TW'(TRIP_CYC - 1);
    localparam logic [RW-1:0] REL_LAST  = RW'(REL_CYC - 1);

    logic [TW-1:0] run_cnt;
    logic [RW-1:0] quiet_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            latched   <= 1'b0;
            run_cnt   <= '0;
            quiet_cnt <= '0;
        end else if (!latched) begin
            quiet_cnt <= '0;
            if (tx_valid) begin
                if (run_cnt == TRIP_LAST) begin
                    latched <= 1'b1;
                    run_cnt <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end else begin
                run_cnt <= '0;
            end
        end else begin
            run_cnt <= '0;
            if (tx_valid) begin
                quiet_cnt <= '0;
            end else if (quiet_cnt == REL_LAST) begin
                latched   <= 1'b0;
                quiet_cnt <= '0;
            end else begin
                quiet_cnt <= quiet_cnt + 1'b1;
            end
        end
    end

    // R2: the latch can only be set on an edge that sampled valid data
    p_set_on_valid_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(latched) |-> $past(tx_valid));

    // R4: the latch can only clear on an edge that sampled a quiet input
    p_clear_on_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(latched) |-> !$past(tx_valid));

endmodule

// File: rtl/heartbeat_timer.sv
module heartbeat_timer
    import coll_pkg::*;
#(
    parameter int unsigned DELAY_CYC = 110,
    parameter int unsigned LEN_CYC   = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_end,
    input  logic hb_en,
    output logic burst
);
    localparam int unsigned CW = cnt_bits(max_u(DELAY_CYC, LEN_CYC));
    localparam logic [CW-1:0] DELAY_LAST = CW'(DELAY_CYC - 1);
    localparam logic [CW-1:0] LEN_LAST   = CW'(LEN_CYC - 1);

    hb_state_e     state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HB_IDLE;
            cnt   <= '0;
        end else if (tx_end && hb_en) begin
            state <= HB_WAIT;
            cnt   <= '0;
        end else begin
            unique case (state)
                HB_WAIT: begin
                    if (cnt == DELAY_LAST) begin
                        state <= HB_BURST;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                HB_BURST: begin
                    if (cnt == LEN_LAST) begin
                        state <= HB_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= HB_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign burst = (state == HB_BURST);

    // R5: a burst is always entered from the delay phase
    p_burst_after_wait_r5: assert property (@(posedge clk) disable iff (rst)
        (state == HB_BURST && $past(state) != HB_BURST) |-> $past(state) == HB_WAIT);

    // R10: an enabled end pulse always lands in the delay phase
    p_retrigger_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_end && hb_en) |=> (state == HB_WAIT));

endmodule

// File: rtl/sq_wave_gen.sv
module sq_wave_gen
    import coll_pkg::*;
#(
    parameter int unsigned DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic out_pos,
    output logic out_neg
);
    localparam int unsigned PW = cnt_bits(DIV);
    localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
    localparam logic [PW-1:0] PH_HALF = PW'(DIV / 2);

    logic [PW-1:0] phase;
    logic          first_half;

    assign first_half = (phase < PH_HALF);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= '0;
            out_pos <= 1'b0;
            out_neg <= 1'b0;
        end else begin
            phase   <= (phase == PH_LAST) ? '0 : phase + 1'b1;
            out_pos <= active & first_half;
            out_neg <= active & ~first_half;
        end
    end

    // R8: the two lines are never high together
    p_complement_r8: assert property (@(posedge clk) disable iff (rst)
        !(out_pos && out_neg));

    // R8: while active, exactly one line is high
    p_one_line_r8: assert property (@(posedge clk) disable iff (rst)
        active |=> $onehot({out_pos, out_neg}));

endmodule

// File: rtl/coll_presence_ctrl.sv
module coll_presence_ctrl
    import coll_pkg::*;
#(
    parameter int unsigned CLK_DIV      = 10,
    parameter int unsigned JAB_TRIP_CYC = 2000,
    parameter int unsigned JAB_REL_CYC  = 5000,
    parameter int unsigned HB_DELAY_CYC = 110,
    parameter int unsigned HB_LEN_CYC   = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_valid,
    input  logic tx_end,
    input  logic coll_flag,
    input  logic hb_en,
    output logic tx_disable,
    output logic cp_pos,
    output logic cp_neg
);
    logic    jab_latched;
    logic    hb_burst;
    cp_req_t req;
    logic    active;

    jabber_timer #(
        .TRIP_CYC (JAB_TRIP_CYC),
        .REL_CYC  (JAB_REL_CYC)
    ) jab_i (
        .clk      (clk),
        .rst      (rst),
        .tx_valid (tx_valid),
        .latched  (jab_latched)
    );

    heartbeat_timer #(
        .DELAY_CYC (HB_DELAY_CYC),
        .LEN_CYC   (HB_LEN_CYC)
    ) hb_i (
        .clk    (clk),
        .rst    (rst),
        .tx_end (tx_end),
        .hb_en  (hb_en),
        .burst  (hb_burst)
    );

    always_comb begin
        req.jabber    = jab_latched;
        req.heartbeat = hb_burst & hb_en;
        req.collision = coll_flag & hb_en;
    end

    assign active     = req_any(req);
    assign tx_disable = jab_latched;

    sq_wave_gen #(
        .DIV (CLK_DIV)
    ) wave_i (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .out_pos (cp_pos),
        .out_neg (cp_neg)
    );

    // R3: a latched transmitter always drives the pair on the next edge
    p_jabber_drives_r3: assert property (@(posedge clk) disable iff (rst)
        tx_disable |=> (cp_pos || cp_neg));

    // R6: with enable low and no jabber, the pair goes idle
    p_enable_gates_r6: assert property (@(posedge clk) disable iff (rst)
        (!hb_en && !tx_disable) |=> (!cp_pos && !cp_neg));

    // R7: an enabled collision flag drives the pair
    p_collision_drives_r7: assert property (@(posedge clk) disable iff (rst)
        (coll_flag && hb_en) |=> (cp_pos || cp_neg));

    // R9: no request means zero differential after the edge
    p_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
        !active |=> (!cp_pos && !cp_neg));

endmodule

// File: tb/coll_presence_ctrl_tb_top.sv
`timescale 1ns/1ps
module coll_presence_ctrl_tb_top;

    localparam int DIV   = 10;
    localparam int TRIP  = 40;
    localparam int REL   = 60;
    localparam int DLY   = 11;
    localparam int LEN   = 10;
    localparam int HALF  = DIV / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_valid = 1'b0, tx_end = 1'b0, coll_flag = 1'b0, hb_en = 1'b1;
    logic tx_disable, cp_pos, cp_neg;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench cycle model
    int m_ph, m_run, m_quiet, m_hbst, m_hbcnt;
    bit m_latch;
    bit exp_pos, exp_neg, exp_dis;
    string exp_tag;

    always #2.5 clk = ~clk;

    coll_presence_ctrl #(
        .CLK_DIV      (DIV),
        .JAB_TRIP_CYC (TRIP),
        .JAB_REL_CYC  (REL),
        .HB_DELAY_CYC (DLY),
        .HB_LEN_CYC   (LEN)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .tx_valid   (tx_valid),
        .tx_end     (tx_end),
        .coll_flag  (coll_flag),
        .hb_en      (hb_en),
        .tx_disable (tx_disable),
        .cp_pos     (cp_pos),
        .cp_neg     (cp_neg)
    );

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_ph = 0; m_run = 0; m_quiet = 0; m_hbst = 0; m_hbcnt = 0;
        m_latch = 0; exp_pos = 0; exp_neg = 0; exp_dis = 0; exp_tag = "R1";
    endfunction

    // advance the model across one clock edge with the given inputs
    function automatic void model_edge(bit v, bit e, bit c, bit h);
        bit req;
        req = m_latch | ((m_hbst == 2) & h) | (c & h);
        exp_pos = req && (m_ph < HALF);
        exp_neg = req && !(m_ph < HALF);
        if (m_latch)            exp_tag = "R3";
        else if (m_hbst == 2 && h) exp_tag = "R5";
        else if (c && h)        exp_tag = "R7";
        else                    exp_tag = "R9";
        m_ph = (m_ph == DIV - 1) ? 0 : m_ph + 1;
        if (!m_latch) begin
            if (v) begin
                if (m_run == TRIP - 1) begin m_latch = 1; m_run = 0; end
                else m_run++;
            end else m_run = 0;
            m_quiet = 0;
        end else begin
            if (v) m_quiet = 0;
            else if (m_quiet == REL - 1) begin m_latch = 0; m_quiet = 0; end
            else m_quiet++;
        end
        if (e && h) begin
            m_hbst = 1; m_hbcnt = 0;
        end else if (m_hbst == 1) begin
            if (m_hbcnt == DLY - 1) begin m_hbst = 2; m_hbcnt = 0; end
            else m_hbcnt++;
        end else if (m_hbst == 2) begin
            if (m_hbcnt == LEN - 1) begin m_hbst = 0; m_hbcnt = 0; end
            else m_hbcnt++;
        end
        exp_dis = m_latch;
    endfunction

    // called at a falling edge: drive, cross one rising edge, compare
    task automatic step(bit v, bit e, bit c, bit h);
        tx_valid = v; tx_end = e; coll_flag = c; hb_en = h;
        model_edge(v, e, c, h);
        @(negedge clk);
        check(exp_tag, "cp_pos", cp_pos, exp_pos);
        check(exp_tag, "cp_neg", cp_neg, exp_neg);
        check(exp_dis ? "R2" : "R4", "tx_disable", tx_disable, exp_dis);
    endtask

    function automatic int pair_on();
        return (cp_pos || cp_neg) ? 1 : 0;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int hi_cnt;
        void'($urandom(32'h1c0ffee));
        model_reset();
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", "tx_disable", tx_disable, 0);
        check("R1", "cp_pos", cp_pos, 0);
        check("R1", "cp_neg", cp_neg, 0);
        rst = 1'b0;

        // R2: trip exactly at the TRIP-th valid cycle, shorter run clears
        repeat (TRIP - 1) step(1, 0, 0, 1);
        step(0, 0, 0, 1);
        check("R2", "short run no trip", tx_disable, 0);
        repeat (TRIP - 1) step(1, 0, 0, 1);
        check("R2", "one before trip", tx_disable, 0);
        step(1, 0, 0, 1);
        check("R2", "trip", tx_disable, 1);
        // R3: active while latched even with enable low
        step(1, 0, 0, 0);
        check("R3", "pair on, enable low", pair_on(), 1);

        // R4: stray valid cycle restarts the quiet window
        repeat (REL - 3) step(0, 0, 0, 0);
        step(1, 0, 0, 0);
        repeat (REL - 1) step(0, 0, 0, 1);
        check("R4", "still latched", tx_disable, 1);
        step(0, 0, 0, 1);
        check("R4", "released", tx_disable, 0);
        repeat (TRIP - 1) step(1, 0, 0, 1);
        check("R4", "trip count restarted", tx_disable, 0);
        repeat (REL) step(0, 0, 0, 1);

        // R5: heartbeat window timing
        step(0, 1, 0, 1);
        repeat (DLY) step(0, 0, 0, 1);
        check("R5", "idle before burst", pair_on(), 0);
        step(0, 0, 0, 1);
        check("R5", "burst start", pair_on(), 1);
        repeat (LEN - 1) step(0, 0, 0, 1);
        check("R5", "burst last", pair_on(), 1);
        step(0, 0, 0, 1);
        check("R5", "burst over", pair_on(), 0);

        // R10: retrigger one cycle before the burst would start
        step(0, 1, 0, 1);
        repeat (DLY - 2) step(0, 0, 0, 1);
        step(0, 1, 0, 1);
        repeat (3) step(0, 0, 0, 1);
        check("R10", "delay restarted", pair_on(), 0);
        repeat (DLY + LEN) step(0, 0, 0, 1);

        // R6: enable low suppresses heartbeat and collision
        step(0, 1, 1, 0);
        for (int i = 0; i < DLY + LEN + 2; i++) begin
            step(0, 0, 1, 0);
            check("R6", "pair idle", pair_on(), 0);
        end

        // R7 and R8: collision gives the square wave, HALF of DIV high
        hi_cnt = 0;
        for (int i = 0; i < 2 * DIV; i++) begin
            step(0, 0, 1, 1);
            check("R7", "pair on", pair_on(), 1);
            hi_cnt += cp_pos ? 1 : 0;
        end
        check("R8", "cp_pos high count", hi_cnt, 2 * HALF);
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        check("R9", "idle after release", pair_on(), 0);

        // random episodes
        for (int ep = 0; ep < 70; ep++) begin
            bit h;
            int len;
            h = ($urandom % 8) != 0;
            len = ($urandom % (TRIP + TRIP / 2)) + 1;
            for (int i = 0; i < len; i++)
                step(1, 0, ($urandom % 16) == 0, h);
            step(0, 1, 0, h);
            len = ($urandom % (REL + REL / 2)) + 1;
            for (int i = 0; i < len; i++) begin
                if (($urandom % 10) == 0) h = ~h;
                step(($urandom % 64) == 0, 0, ($urandom % 12) == 0, h);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule